// File: doc/BRIEF.md
# Phase Window Center Selector

This block picks a sampling phase for a calibrated delay line. After a start pulse it steps the tap select of the line upward from zero to a given maximum. For each tap it first writes the delay-line configuration, then asks an external tuning-command issuer to run one tuning transaction. It waits for the issuer's done strobe and records whether that transaction passed.

While the sweep runs, the block keeps two things: the length of the current run of consecutive passing taps, and the longest such run seen so far together with the tap where that run ends. When the last tap has been tried, the chosen phase is the end of the longest run minus half its length. The block writes that phase to the delay line, shows it on its result port and raises done. If no tap passed, the block raises done and error together and writes no final phase.

The delay-line unit value and the maximum phase are latched on start. The configuration fields appear on the `dly*` outputs, and `dlyWrite` pulses once for every write to the line.

Top module: `phase_center_sel`

## Requirements
- R1: After start, tuning requests are issued for the taps 0, 1, 2, ... up to and including the latched maximum phase, exactly one request per tap and in ascending order.
- R2: Whenever a request is issued, the delay line has been written with enable = 1, sampler = 0, unit = the latched unit value and phase = the tap under test.
- R3: `tuneReq` is a pulse one cycle wide, and `dlyPhase` holds steady from the request until the `tuneDone` strobe that answers it.
- R4: A failing result (`tunePass` = 0) sets the current run to zero. A passing result adds one to the current run. The best length and its end tap are replaced only when the current run is strictly longer than the best, so on a tie the earlier run is kept.
- R5: At the end of the sweep, `finalPhase` = bestEnd - floor(bestLen / 2).
- R6: When at least one tap passed, the selected phase is written to the delay line (one extra `dlyWrite` pulse with `dlyPhase` equal to `finalPhase`) in the same cycle that `done` rises. There are maxPhase + 2 writes in total.
- R7: When no tap passed, `done` and `error` both rise and no final write takes place. There are maxPhase + 1 writes and the line keeps the last swept tap.
- R8: A start pulse clears all run tracking together with `done` and `error`. A start pulse while `busy` is high has no effect on the sweep or its result, and `done` stays low while `busy` is high.
- R9: After reset, `busy`, `done`, `error`, `tuneReq`, `dlyWrite` and `dlyEnable` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a sweep when the block is idle |
| unitIn | input | UNIT_W (7) | Calibrated delay unit value, latched on start |
| maxPhase | input | PHASE_W (4) | Highest tap to try, latched on start |
| tunePass | input | 1 | Result of the tuning transaction, valid with tuneDone |
| tuneDone | input | 1 | The tuning transaction has completed |
| tuneReq | output | 1 | One-cycle request for a tuning transaction |
| dlyEnable | output | 1 | Delay-line enable field |
| dlySampler | output | 1 | Delay-line sampler field |
| dlyUnit | output | UNIT_W (7) | Delay-line unit field |
| dlyPhase | output | PHASE_W (4) | Delay-line tap select |
| dlyWrite | output | 1 | Pulses for each delay-line write |
| finalPhase | output | PHASE_W (4) | Selected centre phase |
| busy | output | 1 | A sweep is in progress |
| done | output | 1 | The sweep has ended; stays high until the next start |
| error | output | 1 | No tap passed; stays high until the next start |

## Verification
The start edge moves the block into its configure state. The configuration write shows on `dlyWrite` one cycle later, and `tuneReq` is high in that same cycle. A `tuneDone` is used only if it arrives at least one cycle after the request. The last result is followed by a step cycle and a final cycle. The edge that ends the final cycle raises `done` together with the final write, and `busy` falls at that same edge. The bench samples every output on the falling clock edge. It drives `tuneDone` a chosen number of cycles (one to three) after the request it sees, and it reads the final write in the first cycle where `done` is high and `busy` is low, so it never samples before a result is due.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CFG,
    ST_REQ,
    ST_WAIT,
    ST_STEP,
    ST_FINAL
  } pcsState_t;

  typedef struct packed {
    logic clearTrack;
    logic writeCfg;
    logic recordResult;
    logic stepPhase;
    logic programFinal;
    logic flagError;
    logic finish;
  } pcsStrobe_t;

endpackage

// File: rtl/pcs_window.sv
module pcs_window #(
  parameter int PHASE_W = 4,
  parameter int RUN_W   = PHASE_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clear,
  input  logic               record,
  input  logic               pass,
  input  logic [PHASE_W-1:0] phase,
  output logic [RUN_W-1:0]   bestLen,
  output logic [PHASE_W-1:0] bestEnd,
  output logic [PHASE_W-1:0] centre
);

  logic [RUN_W-1:0] curRun;
  logic [RUN_W-1:0] nextRun;
  logic [RUN_W-1:0] centreWide;

  assign nextRun    = curRun + RUN_W'(1);
  assign centreWide = {{(RUN_W-PHASE_W){1'b0}}, bestEnd} - (bestLen >> 1);
  assign centre     = centreWide[PHASE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curRun  <= '0;
      bestLen <= '0;
      bestEnd <= '0;
    end else if (clear) begin
      curRun  <= '0;
      bestLen <= '0;
      bestEnd <= '0;
    end else if (record) begin
      if (pass) begin
        curRun <= nextRun;
        if (nextRun > bestLen) begin
          bestLen <= nextRun;
          bestEnd <= phase;
        end
      end else begin
        curRun <= '0;
      end
    end
  end

endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int PHASE_W = 4,
  parameter int UNIT_W  = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  pcsStrobe_t         strobe,
  input  logic [UNIT_W-1:0]  unitIn,
  input  logic [PHASE_W-1:0] maxPhase,
  input  logic               tunePass,
  output logic               atLast,
  output logic               noPass,
  output logic               dlyEnable,
  output logic               dlySampler,
  output logic [UNIT_W-1:0]  dlyUnit,
  output logic [PHASE_W-1:0] dlyPhase,
  output logic               dlyWrite,
  output logic [PHASE_W-1:0] finalPhase,
  output logic               done,
  output logic               error
);

  localparam int RUN_W = PHASE_W + 1;

  logic [UNIT_W-1:0]  unitLat;
  logic [PHASE_W-1:0] maxLat;
  logic [PHASE_W-1:0] phaseCnt;
  logic [RUN_W-1:0]   bestLen;
  logic [PHASE_W-1:0] bestEnd;
  logic [PHASE_W-1:0] centre;

  pcs_window #(.PHASE_W(PHASE_W), .RUN_W(RUN_W)) u_window (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (strobe.clearTrack),
    .record  (strobe.recordResult),
    .pass    (tunePass),
    .phase   (phaseCnt),
    .bestLen (bestLen),
    .bestEnd (bestEnd),
    .centre  (centre)
  );

  assign atLast = (phaseCnt == maxLat);
  assign noPass = (bestLen == '0);

  // sweep position and latched configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitLat  <= '0;
      maxLat   <= '0;
      phaseCnt <= '0;
    end else if (strobe.clearTrack) begin
      unitLat  <= unitIn;
      maxLat   <= maxPhase;
      phaseCnt <= '0;
    end else if (strobe.stepPhase) begin
      phaseCnt <= phaseCnt + PHASE_W'(1);
    end
  end

  // delay-line configuration image
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyEnable  <= 1'b0;
      dlySampler <= 1'b0;
      dlyUnit    <= '0;
      dlyPhase   <= '0;
      dlyWrite   <= 1'b0;
    end else begin
      dlyWrite <= 1'b0;
      if (strobe.writeCfg) begin
        dlyEnable  <= 1'b1;
        dlySampler <= 1'b0;
        dlyUnit    <= unitLat;
        dlyPhase   <= phaseCnt;
        dlyWrite   <= 1'b1;
      end else if (strobe.programFinal) begin
        dlyEnable  <= 1'b1;
        dlySampler <= 1'b0;
        dlyPhase   <= centre;
        dlyWrite   <= 1'b1;
      end
    end
  end

  // result and status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      finalPhase <= '0;
      done       <= 1'b0;
      error      <= 1'b0;
    end else if (strobe.clearTrack) begin
      finalPhase <= '0;
      done       <= 1'b0;
      error      <= 1'b0;
    end else begin
      if (strobe.programFinal) finalPhase <= centre;
      if (strobe.flagError)    error      <= 1'b1;
      if (strobe.finish)       done       <= 1'b1;
    end
  end

endmodule

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       tuneDone,
  input  logic       atLast,
  input  logic       noPass,
  output pcsStrobe_t strobe,
  output logic       tuneReq,
  output logic       busy
);

  pcsState_t state;
  pcsState_t stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.clearTrack = 1'b1;
          stateNext         = ST_CFG;
        end
      end
      ST_CFG: begin
        strobe.writeCfg = 1'b1;
        stateNext       = ST_REQ;
      end
      ST_REQ: begin
        stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (tuneDone) begin
          strobe.recordResult = 1'b1;
          stateNext           = ST_STEP;
        end
      end
      ST_STEP: begin
        if (atLast) begin
          stateNext = ST_FINAL;
        end else begin
          strobe.stepPhase = 1'b1;
          stateNext        = ST_CFG;
        end
      end
      ST_FINAL: begin
        if (noPass) strobe.flagError    = 1'b1;
        else        strobe.programFinal = 1'b1;
        strobe.finish = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign tuneReq = (state == ST_REQ);
  assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/phase_center_sel.sv
module phase_center_sel
  import pcs_pkg::*;
#(
  parameter int PHASE_W = 4,
  parameter int UNIT_W  = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [UNIT_W-1:0]  unitIn,
  input  logic [PHASE_W-1:0] maxPhase,
  input  logic               tunePass,
  input  logic               tuneDone,
  output logic               tuneReq,
  output logic               dlyEnable,
  output logic               dlySampler,
  output logic [UNIT_W-1:0]  dlyUnit,
  output logic [PHASE_W-1:0] dlyPhase,
  output logic               dlyWrite,
  output logic [PHASE_W-1:0] finalPhase,
  output logic               busy,
  output logic               done,
  output logic               error
);

  pcsStrobe_t strobe;
  logic       atLast;
  logic       noPass;

  pcs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .tuneDone (tuneDone),
    .atLast   (atLast),
    .noPass   (noPass),
    .strobe   (strobe),
    .tuneReq  (tuneReq),
    .busy     (busy)
  );

  pcs_datapath #(.PHASE_W(PHASE_W), .UNIT_W(UNIT_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .unitIn     (unitIn),
    .maxPhase   (maxPhase),
    .tunePass   (tunePass),
    .atLast     (atLast),
    .noPass     (noPass),
    .dlyEnable  (dlyEnable),
    .dlySampler (dlySampler),
    .dlyUnit    (dlyUnit),
    .dlyPhase   (dlyPhase),
    .dlyWrite   (dlyWrite),
    .finalPhase (finalPhase),
    .done       (done),
    .error      (error)
  );

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int PHASE_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               tuneReq,
  input logic               tuneDone,
  input logic               dlyEnable,
  input logic               dlySampler,
  input logic [PHASE_W-1:0] dlyPhase,
  input logic               dlyWrite,
  input logic [PHASE_W-1:0] finalPhase,
  input logic               busy,
  input logic               done,
  input logic               error
);

  logic [PHASE_W-1:0] expNext;
  logic               waiting;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expNext <= '0;
      waiting <= 1'b0;
    end else begin
      if (start && !busy)  expNext <= '0;
      else if (tuneReq)    expNext <= dlyPhase + PHASE_W'(1);
      if (tuneReq)         waiting <= 1'b1;
      else if (tuneDone)   waiting <= 1'b0;
    end
  end

  // R1: taps are requested in ascending order starting at zero
  a_r1_ascending: assert property (@(posedge clk) disable iff (!rstN)
    tuneReq |-> dlyPhase == expNext);

  // R2: line enabled and sampler off whenever a request is issued
  a_r2_cfg_on_req: assert property (@(posedge clk) disable iff (!rstN)
    tuneReq |-> (dlyEnable && !dlySampler));

  // R3: request lasts a single cycle
  a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    tuneReq |=> !tuneReq);

  // R3: tap held while a transaction is outstanding
  a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && !tuneReq) |-> $stable(dlyPhase));

  // R6: a successful sweep writes the selected phase as done rises
  a_r6_final_write: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(done) && !error) |-> (dlyWrite && dlyPhase == finalPhase));

  // R7: error comes only with done, and without a final write
  a_r7_err_done: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

  a_r7_no_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> !dlyWrite);

  // R8: done stays low while a sweep runs
  a_r8_busy_done: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

endmodule

bind phase_center_sel pcs_checker #(.PHASE_W(PHASE_W)) u_pcsChecker (.*);

// File: tb/phase_center_sel_bench.sv
module phase_center_sel_bench;

  localparam int PHASE_W = 4;
  localparam int UNIT_W  = 7;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic [UNIT_W-1:0]  unitIn = '0;
  logic [PHASE_W-1:0] maxPhase = '0;
  logic               tunePass = 1'b0;
  logic               tuneDone = 1'b0;
  logic               tuneReq;
  logic               dlyEnable;
  logic               dlySampler;
  logic [UNIT_W-1:0]  dlyUnit;
  logic [PHASE_W-1:0] dlyPhase;
  logic               dlyWrite;
  logic [PHASE_W-1:0] finalPhase;
  logic               busy;
  logic               done;
  logic               error;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  phase_center_sel #(.PHASE_W(PHASE_W), .UNIT_W(UNIT_W)) u_phase_center_sel (
    .clk(clk), .rstN(rstN), .start(start), .unitIn(unitIn), .maxPhase(maxPhase),
    .tunePass(tunePass), .tuneDone(tuneDone), .tuneReq(tuneReq),
    .dlyEnable(dlyEnable), .dlySampler(dlySampler), .dlyUnit(dlyUnit),
    .dlyPhase(dlyPhase), .dlyWrite(dlyWrite), .finalPhase(finalPhase),
    .busy(busy), .done(done), .error(error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runSweep(input int maxP, input logic [15:0] pat, input int lat,
                          input bit pokeStart);
    int cur, best, bestEnd, expFinal, reqs, writes, lastW, cyc, ph, unitVal;
    bit expErr, poked, phaseOk;
    cur = 0; best = 0; bestEnd = 0;
    for (int i = 0; i <= maxP; i++) begin
      if (pat[i]) begin
        cur++;
        if (cur > best) begin best = cur; bestEnd = i; end
      end else cur = 0;
    end
    expErr   = (best == 0);
    expFinal = bestEnd - best / 2;
    unitVal  = (maxP * 9 + lat * 5 + 3) % 128;

    @(negedge clk);
    unitIn = UNIT_W'(unitVal); maxPhase = PHASE_W'(maxP); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    unitIn = '0; maxPhase = '0;
    reqs = 0; writes = 0; lastW = -1; cyc = 0; poked = 0;
    while (!(done && !busy) && cyc < 2000) begin
      if (dlyWrite) begin writes++; lastW = dlyPhase; end
      if (tuneReq) begin
        chk(dlyPhase == PHASE_W'(reqs), "R1 request tap", dlyPhase, reqs);
        chk(dlyEnable && !dlySampler, "R2 enable/sampler", {dlyEnable, dlySampler}, 2);
        chk(dlyUnit == UNIT_W'(unitVal), "R2 unit", dlyUnit, unitVal);
        reqs++;
        ph = dlyPhase;
        phaseOk = 1'b1;
        for (int k = 0; k < lat; k++) begin
          @(negedge clk); cyc++;
          if (tuneReq) phaseOk = 1'b0;
          if (dlyPhase != PHASE_W'(ph)) phaseOk = 1'b0;
          if (pokeStart && !poked) begin start = 1'b1; maxPhase = 4'd1; poked = 1; end
        end
        chk(phaseOk, "R3 request pulse and tap hold", phaseOk, 1);
        tuneDone = 1'b1; tunePass = pat[ph];
        @(negedge clk); cyc++;
        tuneDone = 1'b0; tunePass = 1'b0; start = 1'b0; maxPhase = '0;
      end else begin
        @(negedge clk); cyc++;
      end
    end
    chk(cyc < 2000, "R1 sweep completes", cyc, 0);
    if (dlyWrite) begin writes++; lastW = dlyPhase; end
    chk(reqs == maxP + 1, "R1 request count", reqs, maxP + 1);
    chk(error == expErr, "R7 error flag", error, expErr);
    if (!expErr) begin
      chk(finalPhase == PHASE_W'(expFinal), "R4 R5 final phase", finalPhase, expFinal);
      chk(lastW == expFinal, "R6 final written", lastW, expFinal);
      chk(writes == maxP + 2, "R6 write count", writes, maxP + 2);
    end else begin
      chk(writes == maxP + 1, "R7 no final write", writes, maxP + 1);
      chk(lastW == maxP, "R7 line keeps last tap", lastW, maxP);
    end
    if (pokeStart)
      chk(reqs == maxP + 1, "R8 start while busy ignored", reqs, maxP + 1);
    @(negedge clk);
    chk(!dlyWrite && done && !busy, "R8 idle after sweep", {dlyWrite, done, busy}, 2);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && !tuneReq && !dlyWrite && !dlyEnable, "R9 reset state",
        {busy, done, error, tuneReq, dlyWrite, dlyEnable}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !tuneReq, "R9 idle after reset", {busy, done, tuneReq}, 0);

    for (int p = 0; p < 32; p++)
      runSweep(4, 16'(p), 1 + (p % 3), p == 13);

    runSweep(12, 16'b0000_0001_1100_0111, 2, 0); // R4 tie: earlier run kept
    runSweep(12, 16'b0001_1111_1111_1111, 1, 0); // R5 all pass
    runSweep(12, 16'h0000, 3, 0);                // R7 none pass
    runSweep(0, 16'h0001, 1, 0);
    runSweep(0, 16'h0000, 1, 0);
    runSweep(15, 16'hFFFF, 1, 0);
    runSweep(15, 16'h8000, 2, 1);

    lf = 16'hACE1;
    for (int n = 0; n < 40; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      runSweep(n % 16, lf, 1 + (n % 3), (n % 7) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule